// File: doc/BRIEF.md
# Watchpoint exception report generator

This block sits between a watchpoint hit detector and the exception entry logic of a processor core. Each cycle it may receive a hit strobe along with the properties of the access that caused it. It acts on a hit only when the hit is flagged as owned by the CPU. For such a hit it reads a qualification bit, which is computed elsewhere by the match logic. A qualified hit produces a data-abort request. An unqualified hit produces a resume request, so that the core carries on as if nothing had fired.

On a qualified hit the block also captures three values for the exception entry logic:

- a 32-bit syndrome word describing the watchpoint exception;
- a fault status code, whose encoding depends on the active translation format;
- the data address of the access that hit.

These registers keep their contents until the next qualified hit. Entry logic can therefore read them at any time after the abort request.

Top module: `wp_exc_report`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, abort_req, resume_req, syndrome, fault_status and fault_addr are all zero.
- R2: A cycle with hit_valid=1, hit_cpu=1 and qualified=1 raises abort_req for exactly one cycle, on the cycle after the hit is sampled.
- R3: A cycle with hit_valid=1, hit_cpu=1 and qualified=0 raises resume_req for exactly one cycle, on the cycle after the hit is sampled. abort_req and resume_req are never high together.
- R4: A hit with hit_cpu=0 is ignored, whatever the value of qualified. No request pulse follows it, and syndrome, fault_status and fault_addr keep their values.
- R5: Syndrome bits 31:26 hold the exception class. This is 0x34 ORed with a same-level bit, and the same-level bit is 1 when tgt_lvl equals cur_lvl. The class is therefore 0x35 at the same level and 0x34 otherwise.
- R6: Syndrome bit 6 equals hit_write. Bit 8 (cache maintenance) is 0, bits 5:0 are 0x22, and bits 25:9 and bit 7 are 0.
- R7: fault_status is 0x222 when long_desc=1 at the hit, and 0x002 when long_desc=0.
- R8: fault_addr equals the hit_addr sampled with the qualified hit.
- R9: syndrome, fault_status and fault_addr change only on a cycle where abort_req is high. A resume, or an ignored hit, leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Watchpoint hit strobe, one cycle per hit |
| hit_cpu | input | 1 | Hit belongs to a CPU-programmed watchpoint |
| hit_write | input | 1 | Firing access was a write |
| hit_addr | input | ADDR_W | Data address of the firing access |
| qualified | input | 1 | Match logic says the hit passes all checks |
| tgt_lvl | input | LVL_W | Exception level that debug exceptions target |
| cur_lvl | input | LVL_W | Current exception level |
| long_desc | input | 1 | Long-descriptor translation format is active |
| abort_req | output | 1 | One-cycle data-abort request |
| resume_req | output | 1 | One-cycle resume request |
| syndrome | output | 32 | Captured exception syndrome |
| fault_status | output | 10 | Captured fault status code |
| fault_addr | output | ADDR_W | Captured faulting address |

## Verification
The bench builds the block with ADDR_W=40 and LVL_W=2. The wider address puts bits above 31 into play, so fault_addr is checked beyond a single 32-bit word. With LVL_W=2, the random levels hit both the equal and the unequal case of the same-level bit at a useful rate. The random hits mix every combination of ownership, qualification, write and addressing format. Back-to-back hits check that the request pulses follow the hits cycle by cycle.

// File: rtl/wp_exc_report.sv
module wp_exc_report #(
  parameter int ADDR_W = 32,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_valid,
  input  logic              hit_cpu,
  input  logic              hit_write,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic              qualified,
  input  logic [LVL_W-1:0]  tgt_lvl,
  input  logic [LVL_W-1:0]  cur_lvl,
  input  logic              long_desc,
  output logic              abort_req,
  output logic              resume_req,
  output logic [31:0]       syndrome,
  output logic [9:0]        fault_status,
  output logic [ADDR_W-1:0] fault_addr
);

  localparam logic [5:0] WP_CLASS  = 6'h34;
  localparam logic [5:0] LOW_CODE  = 6'h22;
  localparam logic [9:0] FSR_LONG  = 10'h200 | 10'h022;
  localparam logic [9:0] FSR_SHORT = 10'h002;

  logic        take;
  logic        same_lvl;
  logic [31:0] syn_next;
  logic [9:0]  fsr_next;

  assign take     = hit_valid & hit_cpu;
  assign same_lvl = (tgt_lvl == cur_lvl);
  assign syn_next = {WP_CLASS | {5'b0, same_lvl}, 17'b0, 1'b0, 1'b0, hit_write, LOW_CODE};
  assign fsr_next = long_desc ? FSR_LONG : FSR_SHORT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_req    <= 1'b0;
      resume_req   <= 1'b0;
      syndrome     <= '0;
      fault_status <= '0;
      fault_addr   <= '0;
    end else begin
      abort_req  <= take & qualified;
      resume_req <= take & ~qualified;
      if (take && qualified) begin
        syndrome     <= syn_next;
        fault_status <= fsr_next;
        fault_addr   <= hit_addr;
      end
    end
  end

  // R2
  abort_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_cpu && qualified) |=> abort_req);

  // R3
  resume_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_cpu && !qualified) |=> resume_req);

  // R3
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_req && resume_req));

  // R4
  foreign_hit_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_valid && hit_cpu) |=> !(abort_req || resume_req));

  // R9
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_req |-> ($stable(syndrome) && $stable(fault_status) && $stable(fault_addr)));

  // R8
  addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_cpu && qualified) |=> (fault_addr == $past(hit_addr)));

  // R6
  syn_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> (syndrome[5:0] == 6'h22 && syndrome[8] == 1'b0));

endmodule

// File: tb/tb_wp_exc_report.sv
`timescale 1ns/1ps
module tb_wp_exc_report;
  localparam int AW = 40;
  localparam int LW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit_valid = 0, hit_cpu = 0, hit_write = 0, qualified = 0, long_desc = 0;
  logic [AW-1:0] hit_addr = '0;
  logic [LW-1:0] tgt_lvl = '0, cur_lvl = '0;
  logic abort_req, resume_req;
  logic [31:0] syndrome;
  logic [9:0] fault_status;
  logic [AW-1:0] fault_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  logic exp_abort = 0, exp_resume = 0;
  logic [31:0] exp_syn = '0;
  logic [9:0] exp_fsr = '0;
  logic [AW-1:0] exp_addr = '0;

  always #2 clk = ~clk;

  wp_exc_report #(.ADDR_W(AW), .LVL_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_cpu(hit_cpu),
    .hit_write(hit_write), .hit_addr(hit_addr), .qualified(qualified),
    .tgt_lvl(tgt_lvl), .cur_lvl(cur_lvl), .long_desc(long_desc),
    .abort_req(abort_req), .resume_req(resume_req), .syndrome(syndrome),
    .fault_status(fault_status), .fault_addr(fault_addr));

  function automatic logic [31:0] model_syn(input logic wr, input logic same);
    logic [31:0] s;
    s = 32'h0;
    s[31:26] = 6'h34 | {5'b0, same};
    s[6] = wr;
    s[5:0] = 6'h22;
    return s;
  endfunction

  function automatic logic [9:0] model_fsr(input logic ld);
    return ld ? 10'h222 : 10'h002;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " abort"}, 64'(abort_req), 64'(exp_abort));
    check({req, " resume"}, 64'(resume_req), 64'(exp_resume));
    check({req, " syndrome"}, 64'(syndrome), 64'(exp_syn));
    check({req, " fsr"}, 64'(fault_status), 64'(exp_fsr));
    check({req, " addr"}, 64'(fault_addr), 64'(exp_addr));
  endtask

  task automatic apply(input logic v, input logic c, input logic q, input logic w,
                       input logic [AW-1:0] a, input logic [LW-1:0] t,
                       input logic [LW-1:0] l, input logic ld);
    hit_valid = v; hit_cpu = c; qualified = q; hit_write = w;
    hit_addr = a; tgt_lvl = t; cur_lvl = l; long_desc = ld;
    exp_abort  = v & c & q;
    exp_resume = v & c & ~q;
    if (v && c && q) begin
      exp_syn  = model_syn(w, t == l);
      exp_fsr  = model_fsr(ld);
      exp_addr = a;
    end
  endtask

  task automatic step(input string req);
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    step("R1 after reset");

    // R2 R5 R6 R7 R8: qualified write, same level, long format
    apply(1, 1, 1, 1, 40'hAB_CDEF_0123, 2'd1, 2'd1, 1);
    step("R2 R5 R6 R7 R8 qualified");
    apply(0, 0, 0, 0, '0, 0, 0, 0);
    step("R2 pulse width");
    // R4: foreign hit with qualified set
    apply(1, 0, 1, 0, 40'h11_1111_1111, 2'd0, 2'd2, 0);
    step("R4 foreign hit");
    // R3 R9: unqualified hit keeps registers
    apply(1, 1, 0, 0, 40'h22_2222_2222, 2'd2, 2'd2, 0);
    step("R3 R9 resume");
    // R5 R6 R7: read, different level, short format
    apply(1, 1, 1, 0, 40'hFF_0000_0004, 2'd2, 2'd0, 0);
    step("R5 R6 R7 other level short");
    // back-to-back hits
    apply(1, 1, 0, 1, 40'h33, 2'd3, 2'd3, 1);
    step("R3 back to back resume");
    apply(1, 1, 1, 1, 40'h44, 2'd3, 2'd3, 1);
    step("R2 back to back abort");

    for (int i = 0; i < 3000; i++) begin
      apply($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
            $urandom_range(0, 1) == 1, {$urandom(), $urandom()},
            LW'($urandom_range(0, 3)), LW'($urandom_range(0, 3)), $urandom_range(0, 1) == 1);
      step("R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    apply(0, 0, 0, 0, '0, 0, 0, 0);
    step("R9 idle");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule